// File: doc/BRIEF.md
# Operand Address Generator

This block turns the six-bit operand-location field of an instruction into a memory address for a 32-bit processor with eight data and eight address registers. The field is split into a three-bit mode and a three-bit register number. When the mode is seven, the register number picks one of the special forms: absolute, program-counter-relative or immediate. The block does not decode instructions, read memory or execute anything.

On each valid input cycle the block receives the mode, the register number and the operand size. It also receives the address register contents, the supervisor stack pointer, the program-counter value and up to two 16-bit extension words. It also takes an index value and the privilege bit. One clock later it presents a registered result:
- the operand address;
- a write-back of the updated address register for the stepping modes;
- the count of extension words consumed;
- whether the reference lies in program space;
- an immediate value;
- a flag for register operands;
- a flag for unused encodings.

Top module: `ea_addr_unit`

## Requirements
- R1: Mode 000 and mode 001 raise reg_operand. They give addr_out 0, no write-back and zero extension words.
- R2: Mode 010 gives addr_out equal to the selected address register. It has no write-back and is a data reference.
- R3: Mode 011 gives addr_out equal to the register. It writes back the register plus a step: 1, 2 or 4 for op_size codes 00, 01, 10 (code 11 acts as 10). The write-back raises ar_wr_en, and ar_wr_idx carries the register number.
- R4: Mode 100 gives addr_out equal to the register minus the step of R3, and writes that same value back.
- R5: With register 7 and op_size 00, the step in modes 011 and 100 is 2 instead of 1.
- R6: Register 7 reads ssp_in, and ar_wr_ssp is 1 on its write-back, when super_mode is 1. Otherwise register 7 reads slot 7 of areg_file, and ar_wr_ssp is 0.
- R7: Mode 101 adds the sign-extended ext_word0 to the register, with one extension word.
- R8: Mode 110 adds the sign-extended low byte of ext_word0 and the full 32-bit index_val to the register, modulo 2^32, with one extension word.
- R9: Mode 111 with register 000 gives sign-extended ext_word0 (one word). Register 001 gives {ext_word0, ext_word1} (two words).
- R10: Mode 111 with register 010 adds the sign-extended ext_word0 to pc_ext. Register 011 adds the sign-extended low byte plus index_val to pc_ext. Both set is_program and use one word.
- R11: Mode 111 with register 100 gives addr_out = pc_ext and is_program = 1. It uses one extension word for op_size 00 and 01, and two for longs. imm_value is the zero-extended low byte, the zero-extended word, or {ext_word0, ext_word1} respectively.
- R12: Mode 111 with register 101, 110 or 111 raises illegal_mode. All other result outputs are 0.
- R13: Results appear one cycle after in_valid, with out_valid. Synchronous reset clears every output. Outputs that do not apply to the mode read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| ea_mode | input | 3 | Mode field |
| ea_reg | input | REG_W | Register field |
| op_size | input | 2 | 00 byte, 01 word, 10/11 long |
| super_mode | input | 1 | Privilege state, 1 = supervisor |
| areg_file | input | NREG*AW | Address registers, slot 7 = user stack pointer |
| ssp_in | input | AW | Supervisor stack pointer |
| pc_ext | input | AW | Address of the first extension word |
| ext_word0 | input | EXT_W | First extension word |
| ext_word1 | input | EXT_W | Second extension word |
| index_val | input | AW | Index register contents |
| out_valid | output | 1 | Result strobe |
| addr_out | output | AW | Operand address |
| ar_wr_en | output | 1 | Address register write-back enable |
| ar_wr_idx | output | REG_W | Register written back |
| ar_wr_ssp | output | 1 | Write-back targets the supervisor stack pointer |
| ar_wr_data | output | AW | Write-back value |
| ext_words | output | 2 | Extension words consumed |
| is_program | output | 1 | Program-space reference |
| reg_operand | output | 1 | Operand is a register |
| illegal_mode | output | 1 | Unused encoding |
| imm_value | output | AW | Immediate operand |

## Verification
The bench builds the block with its defaults: AW = 32, EXT_W = 16 and REG_W = 3. With these values the stack register is slot 7, so the byte-step and banking cases on that slot can be reached. With 32-bit arithmetic the bench can drive near-top register values and negative index values and see the modulo-2^32 wrap directly. Requests are streamed back to back, so each result must pair with its own request.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    K_DREG, K_AREG, K_IND, K_POST, K_PRE, K_DISP, K_IDX,
    K_ABSW, K_ABSL, K_PCD, K_PCX, K_IMM, K_BAD
  } ea_kind_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;

endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
  import ea_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic [2:0]       mode,
  input  logic [REG_W-1:0] regf,
  input  logic [1:0]       size,
  output ea_kind_e         kind,
  output logic [2:0]       step,
  output logic [1:0]       ext_cnt
);
  localparam logic [REG_W-1:0] SP_IDX = {REG_W{1'b1}};

  always_comb begin
    case (mode)
      3'b000: kind = K_DREG;
      3'b001: kind = K_AREG;
      3'b010: kind = K_IND;
      3'b011: kind = K_POST;
      3'b100: kind = K_PRE;
      3'b101: kind = K_DISP;
      3'b110: kind = K_IDX;
      default: begin
        case (regf)
          REG_W'(0): kind = K_ABSW;
          REG_W'(1): kind = K_ABSL;
          REG_W'(2): kind = K_PCD;
          REG_W'(3): kind = K_PCX;
          REG_W'(4): kind = K_IMM;
          default:   kind = K_BAD;
        endcase
      end
    endcase
  end

  // step size: the stack slot never steps by one
  always_comb begin
    if (size == SZ_BYTE)      step = (regf == SP_IDX) ? 3'd2 : 3'd1;
    else if (size == SZ_WORD) step = 3'd2;
    else                      step = 3'd4;
  end

  always_comb begin
    case (kind)
      K_DISP, K_IDX, K_ABSW, K_PCD, K_PCX: ext_cnt = 2'd1;
      K_ABSL:                              ext_cnt = 2'd2;
      K_IMM:   ext_cnt = (size == SZ_BYTE || size == SZ_WORD) ? 2'd1 : 2'd2;
      default:                             ext_cnt = 2'd0;
    endcase
  end

endmodule

// File: rtl/ea_base_sel.sv
module ea_base_sel #(
  parameter int AW    = 32,
  parameter int REG_W = 3,
  localparam int NREG = 1 << REG_W
) (
  input  logic [NREG*AW-1:0] areg_file,
  input  logic [AW-1:0]      ssp_in,
  input  logic               super_mode,
  input  logic [REG_W-1:0]   regf,
  output logic [AW-1:0]      base,
  output logic               use_ssp
);
  localparam logic [REG_W-1:0] SP_IDX = {REG_W{1'b1}};

  logic [AW-1:0] slots [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign slots[g] = areg_file[g*AW +: AW];
  end

  assign use_ssp = super_mode && (regf == SP_IDX);
  assign base    = use_ssp ? ssp_in : slots[regf];

endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW    = 32,
  parameter int EXT_W = 16
) (
  input  ea_kind_e         kind,
  input  logic [1:0]       size,
  input  logic [2:0]       step,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    pc,
  input  logic [EXT_W-1:0] ext0,
  input  logic [EXT_W-1:0] ext1,
  input  logic [AW-1:0]    index,
  output logic [AW-1:0]    addr,
  output logic             wr_en,
  output logic [AW-1:0]    wr_data,
  output logic [AW-1:0]    imm,
  output logic             is_prog,
  output logic             reg_op,
  output logic             illegal
);
  logic [AW-1:0] disp16, disp8, step_w, absl, idx_sum;

  assign disp16  = {{(AW-EXT_W){ext0[EXT_W-1]}}, ext0};
  assign disp8   = {{(AW-8){ext0[7]}}, ext0[7:0]};
  assign step_w  = AW'(step);
  assign absl    = AW'({ext0, ext1});
  assign idx_sum = disp8 + index;

  always_comb begin
    addr    = '0;
    wr_en   = 1'b0;
    wr_data = '0;
    imm     = '0;
    is_prog = 1'b0;
    reg_op  = 1'b0;
    illegal = 1'b0;
    case (kind)
      K_DREG, K_AREG: reg_op = 1'b1;
      K_IND:  addr = base;
      K_POST: begin
        addr    = base;
        wr_en   = 1'b1;
        wr_data = base + step_w;
      end
      K_PRE: begin
        addr    = base - step_w;
        wr_en   = 1'b1;
        wr_data = base - step_w;
      end
      K_DISP: addr = base + disp16;
      K_IDX:  addr = base + idx_sum;
      K_ABSW: addr = disp16;
      K_ABSL: addr = absl;
      K_PCD: begin
        addr    = pc + disp16;
        is_prog = 1'b1;
      end
      K_PCX: begin
        addr    = pc + idx_sum;
        is_prog = 1'b1;
      end
      K_IMM: begin
        addr    = pc;
        is_prog = 1'b1;
        if (size == SZ_BYTE)      imm = AW'(ext0[7:0]);
        else if (size == SZ_WORD) imm = AW'(ext0);
        else                      imm = absl;
      end
      default: illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/ea_addr_unit.sv
module ea_addr_unit
  import ea_pkg::*;
#(
  parameter int AW    = 32,
  parameter int EXT_W = 16,
  parameter int REG_W = 3,
  localparam int NREG = 1 << REG_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [2:0]         ea_mode,
  input  logic [REG_W-1:0]   ea_reg,
  input  logic [1:0]         op_size,
  input  logic               super_mode,
  input  logic [NREG*AW-1:0] areg_file,
  input  logic [AW-1:0]      ssp_in,
  input  logic [AW-1:0]      pc_ext,
  input  logic [EXT_W-1:0]   ext_word0,
  input  logic [EXT_W-1:0]   ext_word1,
  input  logic [AW-1:0]      index_val,
  output logic               out_valid,
  output logic [AW-1:0]      addr_out,
  output logic               ar_wr_en,
  output logic [REG_W-1:0]   ar_wr_idx,
  output logic               ar_wr_ssp,
  output logic [AW-1:0]      ar_wr_data,
  output logic [1:0]         ext_words,
  output logic               is_program,
  output logic               reg_operand,
  output logic               illegal_mode,
  output logic [AW-1:0]      imm_value
);
  ea_kind_e      kind;
  logic [2:0]    step;
  logic [1:0]    ext_cnt;
  logic [AW-1:0] base, c_addr, c_wdata, c_imm;
  logic          use_ssp, c_wen, c_prog, c_regop, c_ill;

  ea_mode_dec #(.REG_W(REG_W)) u_dec (
    .mode(ea_mode), .regf(ea_reg), .size(op_size),
    .kind(kind), .step(step), .ext_cnt(ext_cnt)
  );

  ea_base_sel #(.AW(AW), .REG_W(REG_W)) u_sel (
    .areg_file(areg_file), .ssp_in(ssp_in), .super_mode(super_mode),
    .regf(ea_reg), .base(base), .use_ssp(use_ssp)
  );

  ea_calc #(.AW(AW), .EXT_W(EXT_W)) u_calc (
    .kind(kind), .size(op_size), .step(step), .base(base), .pc(pc_ext),
    .ext0(ext_word0), .ext1(ext_word1), .index(index_val),
    .addr(c_addr), .wr_en(c_wen), .wr_data(c_wdata), .imm(c_imm),
    .is_prog(c_prog), .reg_op(c_regop), .illegal(c_ill)
  );

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_valid    <= 1'b0;
      addr_out     <= '0;
      ar_wr_en     <= 1'b0;
      ar_wr_idx    <= '0;
      ar_wr_ssp    <= 1'b0;
      ar_wr_data   <= '0;
      ext_words    <= '0;
      is_program   <= 1'b0;
      reg_operand  <= 1'b0;
      illegal_mode <= 1'b0;
      imm_value    <= '0;
    end else begin
      out_valid    <= 1'b1;
      addr_out     <= c_addr;
      ar_wr_en     <= c_wen;
      ar_wr_idx    <= c_wen ? ea_reg : '0;
      ar_wr_ssp    <= c_wen && use_ssp;
      ar_wr_data   <= c_wdata;
      ext_words    <= ext_cnt;
      is_program   <= c_prog;
      reg_operand  <= c_regop;
      illegal_mode <= c_ill;
      imm_value    <= c_imm;
    end
  end

  // R13
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R1
  regdir_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ea_mode[2:1] == 2'b00) |=>
      (reg_operand && !ar_wr_en && ext_words == 2'd0 && addr_out == '0));

  // R3
  postinc_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ea_mode == 3'b011) |=>
      (ar_wr_en && ((ar_wr_data - addr_out) == AW'(1) ||
                    (ar_wr_data - addr_out) == AW'(2) ||
                    (ar_wr_data - addr_out) == AW'(4))));

  // R4
  predec_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ea_mode == 3'b100) |=> (ar_wr_en && ar_wr_data == addr_out));

  // R5
  sp_byte_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ea_mode == 3'b011 && ea_reg == {REG_W{1'b1}} && op_size == 2'b00)
      |=> (ar_wr_data - addr_out == AW'(2)));

  // R6
  ssp_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ea_mode == 3'b011 && ea_reg == {REG_W{1'b1}} && super_mode)
      |=> (ar_wr_ssp && addr_out == $past(ssp_in)));

  // R10
  pc_class_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ea_mode == 3'b111 && (ea_reg == REG_W'(2) || ea_reg == REG_W'(3)))
      |=> (is_program && ext_words == 2'd1));

  // R12
  illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ea_mode == 3'b111 && ea_reg > REG_W'(4)) |=>
      (illegal_mode && !ar_wr_en && ext_words == 2'd0 && !is_program));

endmodule

// File: tb/sim_ea_addr_unit.sv
module sim_ea_addr_unit;

  typedef struct {
    logic [31:0] addr;
    logic        wen;
    logic [2:0]  widx;
    logic        wssp;
    logic [31:0] wdata;
    logic [1:0]  ext;
    logic        prog;
    logic        regop;
    logic        ill;
    logic [31:0] imm;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  ea_mode = '0;
  logic [2:0]  ea_reg = '0;
  logic [1:0]  op_size = '0;
  logic        super_mode = 1'b0;
  logic [255:0] areg_file;
  logic [31:0] ssp_in = '0, pc_ext = '0, index_val = '0;
  logic [15:0] ext_word0 = '0, ext_word1 = '0;
  logic [31:0] areg [8];

  logic        out_valid, ar_wr_en, ar_wr_ssp, is_program, reg_operand, illegal_mode;
  logic [31:0] addr_out, ar_wr_data, imm_value;
  logic [2:0]  ar_wr_idx;
  logic [1:0]  ext_words;

  int   total = 0;
  int   bad = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < 8; i++) areg_file[i*32 +: 32] = areg[i];

  ea_addr_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ea_mode(ea_mode), .ea_reg(ea_reg),
    .op_size(op_size), .super_mode(super_mode), .areg_file(areg_file),
    .ssp_in(ssp_in), .pc_ext(pc_ext), .ext_word0(ext_word0), .ext_word1(ext_word1),
    .index_val(index_val), .out_valid(out_valid), .addr_out(addr_out),
    .ar_wr_en(ar_wr_en), .ar_wr_idx(ar_wr_idx), .ar_wr_ssp(ar_wr_ssp),
    .ar_wr_data(ar_wr_data), .ext_words(ext_words), .is_program(is_program),
    .reg_operand(reg_operand), .illegal_mode(illegal_mode), .imm_value(imm_value)
  );

  function automatic exp_t model(input logic [2:0] m, input logic [2:0] r,
                                 input logic [1:0] sz, input logic sup, input string tag);
    exp_t e;
    logic [31:0] b, st, d16, d8;
    e = '{addr: 0, wen: 0, widx: 0, wssp: 0, wdata: 0, ext: 0, prog: 0,
          regop: 0, ill: 0, imm: 0, tag: tag};
    b   = (r == 3'd7 && sup) ? ssp_in : areg[r];
    st  = (sz == 2'b00) ? ((r == 3'd7) ? 32'd2 : 32'd1) : (sz == 2'b01) ? 32'd2 : 32'd4;
    d16 = {{16{ext_word0[15]}}, ext_word0};
    d8  = {{24{ext_word0[7]}}, ext_word0[7:0]};
    case (m)
      3'b000, 3'b001: e.regop = 1;
      3'b010: e.addr = b;
      3'b011: begin e.addr = b; e.wen = 1; e.widx = r; e.wssp = (r == 3'd7) && sup; e.wdata = b + st; end
      3'b100: begin e.addr = b - st; e.wen = 1; e.widx = r; e.wssp = (r == 3'd7) && sup; e.wdata = b - st; end
      3'b101: begin e.addr = b + d16; e.ext = 1; end
      3'b110: begin e.addr = b + d8 + index_val; e.ext = 1; end
      default: case (r)
        3'd0: begin e.addr = d16; e.ext = 1; end
        3'd1: begin e.addr = {ext_word0, ext_word1}; e.ext = 2; end
        3'd2: begin e.addr = pc_ext + d16; e.ext = 1; e.prog = 1; end
        3'd3: begin e.addr = pc_ext + d8 + index_val; e.ext = 1; e.prog = 1; end
        3'd4: begin
          e.addr = pc_ext; e.prog = 1;
          if (sz == 2'b00)      begin e.ext = 1; e.imm = {24'd0, ext_word0[7:0]}; end
          else if (sz == 2'b01) begin e.ext = 1; e.imm = {16'd0, ext_word0}; end
          else                  begin e.ext = 2; e.imm = {ext_word0, ext_word1}; end
        end
        default: e.ill = 1;
      endcase
    endcase
    return e;
  endfunction

  task automatic drive(input logic [2:0] m, input logic [2:0] r, input logic [1:0] sz,
                       input logic sup, input string tag);
    ea_mode = m; ea_reg = r; op_size = sz; super_mode = sup; in_valid = 1'b1;
    q.push_back(model(m, r, sz, sup, tag));
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R13 unexpected result: actual addr=%h expected no output", addr_out);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (addr_out !== e.addr || ar_wr_en !== e.wen || ar_wr_idx !== e.widx ||
            ar_wr_ssp !== e.wssp || ar_wr_data !== e.wdata || ext_words !== e.ext ||
            is_program !== e.prog || reg_operand !== e.regop ||
            illegal_mode !== e.ill || imm_value !== e.imm) begin
          bad++;
          $display("FAIL %s actual addr=%h wen=%b idx=%0d ssp=%b wd=%h ext=%0d prog=%b reg=%b ill=%b imm=%h expected addr=%h wen=%b idx=%0d ssp=%b wd=%h ext=%0d prog=%b reg=%b ill=%b imm=%h",
                   e.tag, addr_out, ar_wr_en, ar_wr_idx, ar_wr_ssp, ar_wr_data, ext_words,
                   is_program, reg_operand, illegal_mode, imm_value,
                   e.addr, e.wen, e.widx, e.wssp, e.wdata, e.ext, e.prog, e.regop, e.ill, e.imm);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    areg[0] = 32'h0000_1000; areg[1] = 32'h0000_2000; areg[2] = 32'h0000_3000;
    areg[3] = 32'h4000_0010; areg[4] = 32'h0000_5000; areg[5] = 32'h0000_6000;
    areg[6] = 32'hFFFF_FFFE; areg[7] = 32'h0000_7000;
    ssp_in = 32'h8000_0100; pc_ext = 32'h0001_0002; index_val = 32'hFFFF_FFF0;
    ext_word0 = 16'h1234; ext_word1 = 16'h5678;
    // R13 reset holds outputs clear even with a request present
    ea_mode = 3'b011; ea_reg = 3'd1; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || addr_out !== 32'd0 || ar_wr_en !== 1'b0) begin
      bad++;
      $display("FAIL R13 reset: actual valid=%b addr=%h wen=%b expected 0 0 0",
               out_valid, addr_out, ar_wr_en);
    end
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    drive(3'b000, 3'd2, 2'b10, 0, "R1 data register direct");
    drive(3'b001, 3'd5, 2'b01, 0, "R1 address register direct");
    drive(3'b010, 3'd3, 2'b10, 0, "R2 indirect");
    drive(3'b011, 3'd1, 2'b00, 0, "R3 postinc byte");
    drive(3'b011, 3'd1, 2'b01, 0, "R3 postinc word");
    drive(3'b011, 3'd1, 2'b10, 0, "R3 postinc long");
    drive(3'b011, 3'd6, 2'b11, 0, "R3 postinc wrap");
    drive(3'b100, 3'd2, 2'b00, 0, "R4 predec byte");
    drive(3'b100, 3'd2, 2'b01, 0, "R4 predec word");
    drive(3'b100, 3'd0, 2'b10, 0, "R4 predec long");
    drive(3'b011, 3'd7, 2'b00, 0, "R5 R6 user stack postinc byte");
    drive(3'b100, 3'd7, 2'b00, 1, "R5 R6 supervisor stack predec byte");
    drive(3'b011, 3'd7, 2'b01, 1, "R6 supervisor stack postinc word");
    drive(3'b010, 3'd7, 2'b10, 1, "R6 supervisor stack indirect");
    drive(3'b101, 3'd4, 2'b01, 0, "R7 displacement positive");
    ext_word0 = 16'hFF00;
    drive(3'b101, 3'd4, 2'b01, 0, "R7 displacement negative");
    ext_word0 = 16'h7F80;
    drive(3'b110, 3'd5, 2'b10, 0, "R8 index negative byte");
    ext_word0 = 16'h0012; index_val = 32'h0000_0100; areg[5] = 32'hFFFF_FF00;
    drive(3'b110, 3'd5, 2'b10, 0, "R8 index wrap");
    ext_word0 = 16'h8000;
    drive(3'b111, 3'd0, 2'b01, 0, "R9 absolute short negative");
    ext_word0 = 16'h00AB; ext_word1 = 16'hCDEF;
    drive(3'b111, 3'd1, 2'b01, 0, "R9 absolute long");
    ext_word0 = 16'hFFFE;
    drive(3'b111, 3'd2, 2'b01, 0, "R10 pc displacement");
    ext_word0 = 16'h0004; index_val = 32'h0000_0020;
    drive(3'b111, 3'd3, 2'b01, 0, "R10 pc index");
    ext_word0 = 16'hA5C3; ext_word1 = 16'h1122;
    drive(3'b111, 3'd4, 2'b00, 0, "R11 immediate byte");
    drive(3'b111, 3'd4, 2'b01, 0, "R11 immediate word");
    drive(3'b111, 3'd4, 2'b10, 0, "R11 immediate long");
    drive(3'b111, 3'd5, 2'b10, 0, "R12 illegal 5");
    drive(3'b111, 3'd6, 2'b00, 1, "R12 illegal 6");
    drive(3'b111, 3'd7, 2'b01, 0, "R12 illegal 7");
    in_valid = 1'b0;
    @(negedge clk);
    // R13 idle cycle: no result without a request
    total++;
    if (out_valid !== 1'b0 || ar_wr_en !== 1'b0) begin
      bad++;
      $display("FAIL R13 idle: actual valid=%b wen=%b expected 0 0", out_valid, ar_wr_en);
    end
    drive(3'b100, 3'd3, 2'b10, 0, "R4 after gap");
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R13 missing results: actual pending=%0d expected 0", q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule